// File: doc/BRIEF.md
# CAN Receive Message Queue

This block buffers complete CAN frames handed over by a protocol engine until a host processor reads them. It holds two independent queues. Each queue stores up to three messages, and each message is four 32-bit words: the identifier, an information word (payload length, receive timestamp and the index of the acceptance filter that matched the frame), the low four data bytes and the high four data bytes. A push interface delivers one whole message per cycle, together with a selector that picks the target queue.

The host sees only the oldest message of a queue. It reads that message through a four-word window, which is combinational on a queue selector and a word selector. It discards the message with a one-cycle release pulse, and the next message appears in the window on the following cycle. Each queue reports a 2-bit pending count, a full flag and a sticky overrun flag. The window is read-only. A host write attempt changes nothing and is answered with an error pulse.

When a message arrives at a full queue and no release frees a slot in the same cycle, the overrun flag is set. By default the new message is dropped. A parameter instead lets it overwrite the newest stored entry.

Top module: `canrx_msg_queue`

## Requirements
- R1: After reset every queue has pending count 0, full and overrun low, the window reads 0 for every word selector, and the write error output is low.
- R2: Each queue returns messages in arrival order and keeps up to three of them. The window shows the oldest message of the queue chosen by `rd_q`, with word selector 0 giving the identifier, 1 the information word, 2 the low data word and 3 the high data word. An empty queue reads as 0.
- R3: The information word holds the payload length in bits 3:0, zeros in bits 7:4, the filter index in bits 15:8 and the timestamp in bits 31:16.
- R4: A release pulse on a non-empty queue removes its oldest message. On the next cycle the window shows the following message, and the count is one lower.
- R5: `lvl` gives the pending count of queue q in bits 2q+1:2q. `full[q]` is high exactly when that count is 3.
- R6: A push to a full queue with no release of that queue in the same cycle drops the new message, leaves the count at 3 and the window unchanged, and sets `ovr[q]` on the next cycle. `ovr[q]` stays set until a release removes a message from that queue.
- R7: A release of an empty queue has no effect: the count stays 0 and the overrun flag keeps its value.
- R8: A push and a release of the same queue in one cycle both take effect. On a full queue the push is accepted and no overrun is raised.
- R9: A host write attempt (`wr_en` high) changes no stored message or status. `wr_err` goes high on the cycle after each attempt.
- R10: Pushes to, releases of and reads from one queue leave the contents, count and flags of the other queue unchanged. `push_q` selects the target of a push, and `rel[q]` releases queue q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | A complete message is offered this cycle |
| push_q | input | 1 | Queue that receives the pushed message |
| push_id | input | 32 | Identifier word |
| push_len | input | 4 | Payload length |
| push_stamp | input | 16 | Receive timestamp |
| push_fidx | input | 8 | Index of the matching acceptance filter |
| push_lo | input | 32 | Data bytes 0 to 3 |
| push_hi | input | 32 | Data bytes 4 to 7 |
| rel | input | 2 | Per-queue release pulse |
| rd_q | input | 1 | Queue shown in the read window |
| rd_sel | input | 2 | Word of the oldest message to read |
| rd_data | output | 32 | Selected word, 0 when the queue is empty |
| wr_en | input | 1 | Host write attempt into the window |
| wr_err | output | 1 | Error response to a write attempt |
| lvl | output | 4 | Pending counts, 2 bits per queue |
| full | output | 2 | Per-queue full flag |
| ovr | output | 2 | Per-queue sticky overrun flag |

## Verification
The scoreboard targets the full-queue edge. A push at count 3 must be dropped without disturbing the oldest entry, so a design that overwrites or advances the write pointer would show the wrong word after later releases. A push combined with a release at count 3 must be accepted, so a design that checks fullness before the pop would drop it and raise a false overrun. A release at count 0 must leave the count at 0, where a bad design would wrap it to 3. Other checks cover write attempts on the read-only window, pointer wrap-around over many mixed operations, and cross-talk between the two queues.

// File: rtl/canrx_pkg.sv
// Package: shared message type and information-word packing for the CAN
// receive queue. Assumes 32-bit host words and four words per message.
package canrx_pkg;
    localparam int WORD_W  = 32;
    localparam int LEN_W   = 4;
    localparam int STAMP_W = 16;
    localparam int FIDX_W  = 8;
    localparam int SEL_W   = 2;

    typedef struct packed {
        logic [WORD_W-1:0] id;
        logic [WORD_W-1:0] info;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
    } canrx_msg_t;

    // Build the information word: length 3:0, filter index 15:8, stamp 31:16.
    function automatic logic [WORD_W-1:0] pack_info(
        input logic [LEN_W-1:0]   len,
        input logic [STAMP_W-1:0] stamp,
        input logic [FIDX_W-1:0]  fidx
    );
        return {stamp, fidx, 4'b0000, len};
    endfunction
endpackage

// File: rtl/canrx_ctrl.sv
// canrx_ctrl: pointer, count and overrun control for one queue.
// Assumes DEPTH >= 2 and at most one push and one release per cycle.
// A release of an empty queue is ignored; a release frees a slot for a
// push in the same cycle. OVR_KEEP_NEW chooses drop-new or overwrite-newest.
module canrx_ctrl #(
    parameter int DEPTH        = 3,
    parameter bit OVR_KEEP_NEW = 1'b0,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             rel,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] level,
    output logic             full,
    output logic             ovr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CMAX = CNT_W'(DEPTH);

    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovr_q;
    logic             pop, accept, clash;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] back(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST : p - PTR_W'(1);
    endfunction

    // Decide which requests take effect this cycle.
    always_comb begin
        pop    = rel && (cnt_q != '0);
        accept = push && ((cnt_q != CMAX) || pop);
        clash  = push && (cnt_q == CMAX) && !pop;
    end

    // Select the storage slot according to the overrun policy.
    generate
        if (OVR_KEEP_NEW) begin : g_keep_new
            assign wr_en  = accept || clash;
            assign wr_ptr = clash ? back(wptr_q) : wptr_q;
        end else begin : g_drop_new
            assign wr_en  = accept;
            assign wr_ptr = wptr_q;
        end
    endgenerate

    // Advance pointers and the pending count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (accept) wptr_q <= step(wptr_q);
            if (pop)    rptr_q <= step(rptr_q);
            case ({accept, pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Sticky overrun flag, cleared by an effective release.
    always_ff @(posedge clk) begin
        if (!rst_n)     ovr_q <= 1'b0;
        else if (clash) ovr_q <= 1'b1;
        else if (pop)   ovr_q <= 1'b0;
    end

    assign rd_ptr = rptr_q;
    assign level  = cnt_q;
    assign full   = (cnt_q == CMAX);
    assign ovr    = ovr_q;
endmodule

// File: rtl/canrx_store.sv
// canrx_store: DEPTH message slots for one queue, one write port and one
// combinational read port. Assumes the controller only writes free slots.
module canrx_store
    import canrx_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] wptr,
    input  canrx_msg_t       wdata,
    input  logic [PTR_W-1:0] rptr,
    output canrx_msg_t       rdata
);
    canrx_msg_t slot [DEPTH];

    // Write an incoming message into its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else if (we) begin
            slot[wptr] <= wdata;
        end
    end

    // Present the oldest slot.
    assign rdata = slot[rptr];
endmodule

// File: rtl/canrx_window.sv
// canrx_window: read-only four-word window onto the oldest message of the
// selected queue. Reads zero when that queue is empty.
module canrx_window
    import canrx_pkg::*;
#(
    parameter int NQ = 2,
    localparam int Q_W = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  canrx_msg_t        head [NQ],
    input  logic [NQ-1:0]     has,
    input  logic [Q_W-1:0]    rd_q,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data
);
    canrx_msg_t pick;

    // Choose the queue, then the word within its oldest message.
    always_comb begin
        pick = head[rd_q];
        if (!has[rd_q]) begin
            rd_data = '0;
        end else begin
            case (rd_sel)
                2'd0:    rd_data = pick.id;
                2'd1:    rd_data = pick.info;
                2'd2:    rd_data = pick.lo;
                default: rd_data = pick.hi;
            endcase
        end
    end
endmodule

// File: rtl/canrx_msg_queue.sv
// canrx_msg_queue: NQ independent receive queues of DEPTH CAN messages with
// a shared push port and a shared read-only window. Assumes one push per
// cycle and pulse-style release requests; host writes are rejected.
module canrx_msg_queue
    import canrx_pkg::*;
#(
    parameter int NQ           = 2,
    parameter int DEPTH        = 3,
    parameter bit OVR_KEEP_NEW = 1'b0,
    localparam int Q_W   = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_valid,
    input  logic [Q_W-1:0]      push_q,
    input  logic [WORD_W-1:0]   push_id,
    input  logic [LEN_W-1:0]    push_len,
    input  logic [STAMP_W-1:0]  push_stamp,
    input  logic [FIDX_W-1:0]   push_fidx,
    input  logic [WORD_W-1:0]   push_lo,
    input  logic [WORD_W-1:0]   push_hi,
    input  logic [NQ-1:0]       rel,
    input  logic [Q_W-1:0]      rd_q,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [WORD_W-1:0]   rd_data,
    input  logic                wr_en,
    output logic                wr_err,
    output logic [NQ*CNT_W-1:0] lvl,
    output logic [NQ-1:0]       full,
    output logic [NQ-1:0]       ovr
);
    canrx_msg_t    incoming;
    canrx_msg_t    head [NQ];
    logic [NQ-1:0] has;
    logic          err_q;

    // Assemble the message as it will be stored.
    always_comb begin
        incoming.id   = push_id;
        incoming.info = pack_info(push_len, push_stamp, push_fidx);
        incoming.lo   = push_lo;
        incoming.hi   = push_hi;
    end

    generate
        for (genvar g = 0; g < NQ; g++) begin : g_queue
            logic             q_push, q_we;
            logic [PTR_W-1:0] q_wptr, q_rptr;
            logic [CNT_W-1:0] q_lvl;

            assign q_push = push_valid && (push_q == Q_W'(g));

            canrx_ctrl #(.DEPTH(DEPTH), .OVR_KEEP_NEW(OVR_KEEP_NEW)) u_ctrl (
                .clk(clk), .rst_n(rst_n), .push(q_push), .rel(rel[g]),
                .wr_en(q_we), .wr_ptr(q_wptr), .rd_ptr(q_rptr),
                .level(q_lvl), .full(full[g]), .ovr(ovr[g])
            );

            canrx_store #(.DEPTH(DEPTH)) u_store (
                .clk(clk), .rst_n(rst_n), .we(q_we), .wptr(q_wptr),
                .wdata(incoming), .rptr(q_rptr), .rdata(head[g])
            );

            assign lvl[g*CNT_W +: CNT_W] = q_lvl;
            assign has[g]                = (q_lvl != '0);
        end
    endgenerate

    canrx_window #(.NQ(NQ)) u_window (
        .head(head), .has(has), .rd_q(rd_q), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    // Answer every write attempt on the protected window with an error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= wr_en;
    end

    assign wr_err = err_q;
endmodule

// File: rtl/canrx_checker.sv
// canrx_checker: protocol properties for queue 0 of canrx_msg_queue and for
// the write-error response; attached by bind below.
module canrx_checker #(
    parameter int NQ    = 2,
    parameter int DEPTH = 3,
    localparam int Q_W   = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                push_valid,
    input logic [Q_W-1:0]      push_q,
    input logic [NQ-1:0]       rel,
    input logic [Q_W-1:0]      rd_q,
    input logic [31:0]         rd_data,
    input logic                wr_en,
    input logic                wr_err,
    input logic [NQ*CNT_W-1:0] lvl,
    input logic [NQ-1:0]       ovr
);
    localparam logic [CNT_W-1:0] CMAX = CNT_W'(DEPTH);
    logic [CNT_W-1:0] l0;
    logic             p0;
    assign l0 = lvl[CNT_W-1:0];
    assign p0 = push_valid && (push_q == '0);

    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        l0 <= CMAX);
    p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (p0 && !rel[0] && l0 != CMAX) |=> (l0 == $past(l0) + CNT_W'(1)));
    p_release_pops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rel[0] && !p0 && l0 != '0) |=> (l0 == $past(l0) - CNT_W'(1) && !ovr[0]));
    p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (p0 && !rel[0] && l0 == CMAX) |=> (ovr[0] && l0 == CMAX));
    p_empty_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel[0] && !p0 && l0 == '0) |=> (l0 == '0 && ovr[0] == $past(ovr[0])));
    p_push_rel_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (p0 && rel[0] && l0 == CMAX) |=> (l0 == CMAX && !ovr[0]));
    p_write_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> wr_err);
    p_empty_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q == '0 && l0 == '0) |-> (rd_data == '0));
    p_isolation_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!p0 && !rel[0]) |=> (l0 == $past(l0) && ovr[0] == $past(ovr[0])));
endmodule

bind canrx_msg_queue canrx_checker #(.NQ(NQ), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_canrx_msg_queue.sv
// Scoreboard bench: driver tasks keep a model queue per hardware queue;
// the monitor task compares the window with the model head.
module sim_canrx_msg_queue;
    import canrx_pkg::*;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [0:0]  push_q = '0;
    logic [31:0] push_id = '0, push_lo = '0, push_hi = '0;
    logic [3:0]  push_len = '0;
    logic [15:0] push_stamp = '0;
    logic [7:0]  push_fidx = '0;
    logic [1:0]  rel = '0;
    logic [0:0]  rd_q = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0, wr_err;
    logic [3:0]  lvl;
    logic [1:0]  full, ovr;

    int checks = 0, errors = 0;
    bit done = 0;
    canrx_msg_t mq0 [$];
    canrx_msg_t mq1 [$];
    bit         movr [2];

    always #10 clk = ~clk;

    canrx_msg_queue u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic canrx_msg_t mk(input int n);
        canrx_msg_t m;
        m.id   = 32'h0A00_0000 + n * 32'h111;
        m.info = {16'(n * 7 + 3), 8'(n + 1), 4'b0000, 4'(n % 9)};
        m.lo   = 32'hC0DE_0000 ^ (n * 32'h1357);
        m.hi   = 32'h5EED_0000 + n;
        return m;
    endfunction

    function automatic int msize(input int q);
        return (q == 0) ? mq0.size() : mq1.size();
    endfunction

    // Driver: one cycle with optional push and release; updates the model.
    task automatic op(input int q, input bit p, input bit r, input int n);
        canrx_msg_t m = mk(n);
        push_valid = p; push_q = 1'(q);
        push_id = m.id; push_len = m.info[3:0]; push_fidx = m.info[15:8];
        push_stamp = m.info[31:16]; push_lo = m.lo; push_hi = m.hi;
        rel = '0; rel[q] = r;
        @(negedge clk);
        push_valid = 1'b0; rel = '0;
        if (r && msize(q) > 0) begin
            if (q == 0) void'(mq0.pop_front()); else void'(mq1.pop_front());
            movr[q] = 0;
        end
        if (p) begin
            if (msize(q) < 3) begin
                if (q == 0) mq0.push_back(m); else mq1.push_back(m);
            end else movr[q] = 1;
        end
    endtask

    // Monitor: compare status and the four window words with the model head.
    task automatic mon(input int q, input string req);
        canrx_msg_t e;
        logic [31:0] w [4];
        int sz = msize(q);
        if (sz > 0) e = (q == 0) ? mq0[0] : mq1[0]; else e = '0;
        w[0] = e.id; w[1] = e.info; w[2] = e.lo; w[3] = e.hi;
        chk(lvl[q*2 +: 2] == 2'(sz), {req, " R5 level"}, 32'(lvl[q*2 +: 2]), 32'(sz));
        chk(full[q] == (sz == 3), {req, " R5 full"}, 32'(full[q]), 32'(sz == 3));
        chk(ovr[q] == movr[q], {req, " R6 ovr"}, 32'(ovr[q]), 32'(movr[q]));
        for (int s = 0; s < 4; s++) begin
            rd_q = 1'(q); rd_sel = 2'(s); #1;
            chk(rd_data == w[s], {req, " R2 window"}, rd_data, w[s]);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n = 100;
        logic [15:0] lf = 16'hACE1;
        movr[0] = 0; movr[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(lvl == '0 && full == '0 && ovr == '0, "R1 status", {24'b0, lvl, full, ovr}, 0);
        chk(wr_err == 1'b0, "R1 wr_err", 32'(wr_err), 0);
        mon(0, "R1"); mon(1, "R1");
        // R2/R3 ordering and info layout
        op(0, 1, 0, 1); mon(0, "R2 one");
        rd_q = 0; rd_sel = 1; #1;
        chk(rd_data == {16'd10, 8'd2, 4'd0, 4'd1}, "R3 info layout", rd_data, {16'd10, 8'd2, 4'd0, 4'd1});
        op(0, 1, 0, 2); mon(0, "R2 two");
        op(0, 1, 0, 3); mon(0, "R5 full");
        // R6 overrun drops new message
        op(0, 1, 0, 4); mon(0, "R6 drop");
        chk(ovr[0] == 1'b1, "R6 flag", 32'(ovr[0]), 1);
        // R4 release exposes next, clears overrun
        op(0, 0, 1, 0); mon(0, "R4 next");
        chk(ovr[0] == 1'b0, "R6 clear", 32'(ovr[0]), 0);
        // R8 push and release together at full
        op(0, 1, 0, 5); mon(0, "R8 fill");
        op(0, 1, 1, 6); mon(0, "R8 both");
        chk(ovr[0] == 1'b0, "R8 no overrun", 32'(ovr[0]), 0);
        // R10 other queue untouched
        mon(1, "R10 idle");
        op(1, 1, 0, 7); mon(1, "R10 q1"); mon(0, "R10 q0 kept");
        // Drain, then R7 release on empty
        repeat (3) begin op(0, 0, 1, 0); mon(0, "R4 drain"); end
        op(0, 0, 1, 0); mon(0, "R7 empty");
        chk(lvl[1:0] == 2'd0, "R7 level", 32'(lvl[1:0]), 0);
        op(0, 1, 1, 8); mon(0, "R8 empty both");
        // R9 write attempt
        wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
        chk(wr_err == 1'b1, "R9 wr_err", 32'(wr_err), 1);
        mon(0, "R9 unchanged"); mon(1, "R9 unchanged");
        @(negedge clk);
        chk(wr_err == 1'b0, "R9 wr_err drop", 32'(wr_err), 0);
        // Mixed traffic across both queues with wrap-around
        for (int i = 0; i < 400; i++) begin
            int q;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            q = int'(lf[0]);
            n++;
            op(q, lf[1] | lf[3], lf[2] & ~lf[4], n);
            mon(0, "R10 mix"); mon(1, "R10 mix");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule